// File: doc/BRIEF.md
# Frame Buffer Address Generator

This block turns a stream of converted samples into memory write requests for one timer frame at a time. A trigger opens a frame and captures the configuration. Each sample that arrives during the frame is forwarded as a write. The write address is the captured base pointer, plus a running frame offset, plus the per-sample offset carried with the sample. The write data is the sample itself. The sample flagged as last closes the frame.

When a frame closes, the frame offset moves forward by a programmable step. When the ring size is zero, the offset keeps growing, wrapping only at the address width. When the ring size is a nonzero M, the offset returns to zero after M frames, so the oldest frame is overwritten. A step of zero places every frame at the same location.

The block raises a one-cycle completion pulse once the last write of a frame is accepted. It keeps two sticky fault flags, each cleared by the next accepted trigger. One flag reports a write that the memory side rejected. The other reports a frame that took longer than a programmable cycle budget.

Top module: `frame_addr_gen`

## Requirements
- R1: Every accepted write carries `wr_addr` = captured base + frame offset + `ev_offset`, taken modulo 2^AW, and `wr_data` = `ev_data`.
- R2: With ring size 0, the frame offset starts at 0 after reset and grows by the captured step after each completed frame.
- R3: With ring size M > 0, the frame offset goes back to 0 after M completed frames. Frame k (counting from 0) therefore uses offset (k mod M) × step.
- R4: A step of 0 gives every frame the same addresses.
- R5: Base, step, ring size and cycle budget are captured only when a trigger is accepted. Changing them during a frame has no effect on that frame.
- R6: `frame_irq` is high for exactly the one cycle that follows the cycle in which the write marked `ev_last` is accepted, and at no other time.
- R7: An accepted write with `wr_fail` high sets `mem_err`. The flag stays set until the next accepted trigger clears it.
- R8: With a nonzero budget L, `bw_err` is set when the frame length exceeds L. Frame length is the count of cycles from the first write request through the acceptance of the last write. The flag stays set until the next accepted trigger clears it. A budget of 0 disables the check.
- R9: No write is requested, and `ev_ready` stays low, while no frame is open. A trigger that arrives while a frame is open is ignored: the configuration is not recaptured and the flags are not cleared.
- R10: After reset, `wr_valid`, `ev_ready`, `frame_irq`, `mem_err` and `bw_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Base pointer |
| cfg_incr | input | AW | Frame offset step |
| cfg_circ | input | CW | Ring size in frames, 0 means linear |
| cfg_limit | input | LW | Frame cycle budget, 0 disables the check |
| trig | input | 1 | Frame start request |
| ev_valid | input | 1 | Sample present |
| ev_ready | output | 1 | Sample taken this cycle |
| ev_offset | input | AW | Sample offset within the frame |
| ev_data | input | DW | Sample value |
| ev_last | input | 1 | Sample closes the frame |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Memory side accepts the write |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_fail | input | 1 | Accepted write was rejected by memory |
| frame_irq | output | 1 | Frame complete pulse |
| mem_err | output | 1 | Sticky write failure flag |
| bw_err | output | 1 | Sticky over-budget flag |

## Verification
The cases that are hardest to reach from the ports are the boundary of the cycle budget and a trigger that arrives while a frame is open. For the budget, the stimulus stretches a frame by holding `wr_ready` low for a chosen number of cycles. Frame lengths of exactly L and L+1 are then placed on either side of the threshold. For the mid-frame trigger, a write failure is injected first, and then a trigger and a new base are presented while the frame is still open. The sticky flag surviving, and the addresses keeping the old base, show that the trigger was ignored. The ring wrap is checked over more frames than the ring size, and the predicted addresses come from a separate model of the offset sequence.

// File: rtl/frame_addr_gen.sv
module frame_addr_gen #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_incr,
  input  logic [CW-1:0] cfg_circ,
  input  logic [LW-1:0] cfg_limit,
  input  logic          trig,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [AW-1:0] ev_offset,
  input  logic [DW-1:0] ev_data,
  input  logic          ev_last,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_fail,
  output logic          frame_irq,
  output logic          mem_err,
  output logic          bw_err
);
  localparam logic [LW-1:0] TMR_MAX = {LW{1'b1}};

  logic          active, started;
  logic [AW-1:0] base_q, incr_q, off_q;
  logic [CW-1:0] circ_q, cnt_q;
  logic [LW-1:0] lim_q, tmr_q;

  wire start  = trig && !active;
  wire fire   = wr_valid && wr_ready;
  wire done   = fire && ev_last;
  wire [CW-1:0] cnt_nx = cnt_q + 1'b1;

  assign wr_valid = ev_valid && active;
  assign ev_ready = wr_ready && active;
  assign wr_addr  = base_q + off_q + ev_offset;
  assign wr_data  = ev_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      started   <= 1'b0;
      base_q    <= '0;
      incr_q    <= '0;
      circ_q    <= '0;
      lim_q     <= '0;
      off_q     <= '0;
      cnt_q     <= '0;
      tmr_q     <= '0;
      frame_irq <= 1'b0;
      mem_err   <= 1'b0;
      bw_err    <= 1'b0;
    end else begin
      frame_irq <= done;
      if (start) begin
        active  <= 1'b1;
        started <= 1'b0;
        tmr_q   <= '0;
        base_q  <= cfg_base;
        incr_q  <= cfg_incr;
        circ_q  <= cfg_circ;
        lim_q   <= cfg_limit;
        mem_err <= 1'b0;
        bw_err  <= 1'b0;
      end
      if (active && !started && wr_valid) begin
        started <= 1'b1;
        tmr_q   <= 1;
      end else if (active && started && tmr_q != TMR_MAX) begin
        tmr_q <= tmr_q + 1'b1;
      end
      if (active && started && lim_q != '0 && tmr_q >= lim_q)
        bw_err <= 1'b1;
      if (fire && wr_fail)
        mem_err <= 1'b1;
      if (done) begin
        active <= 1'b0;
        if (circ_q == '0) begin
          off_q <= off_q + incr_q;
          cnt_q <= '0;
        end else if (cnt_nx >= circ_q) begin
          off_q <= '0;
          cnt_q <= '0;
        end else begin
          off_q <= off_q + incr_q;
          cnt_q <= cnt_nx;
        end
      end
    end
  end

  // R6
  irq_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> $past(wr_valid && wr_ready && ev_last));
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);
  // R7
  mem_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_fail) |=> mem_err);
  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(base_q) && $stable(incr_q) && $stable(circ_q)));
  // R8
  bw_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bw_err) |-> (lim_q != '0));
  // R3
  ring_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && circ_q != '0 && cnt_nx >= circ_q) |=> (off_q == '0));
endmodule

// File: tb/frame_addr_gen_tb.sv
module frame_addr_gen_tb;
  localparam int AW = 16, DW = 16, CW = 8, LW = 12;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] cfg_base = 0, cfg_incr = 0;
  logic [CW-1:0] cfg_circ = 0;
  logic [LW-1:0] cfg_limit = 0;
  logic trig = 0, ev_valid = 0, ev_last = 0, wr_ready = 0, wr_fail = 0;
  logic [AW-1:0] ev_offset = 0;
  logic [DW-1:0] ev_data = 0;
  logic ev_ready, wr_valid, frame_irq, mem_err, bw_err;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  frame_addr_gen #(.AW(AW), .DW(DW), .CW(CW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_incr(cfg_incr),
    .cfg_circ(cfg_circ), .cfg_limit(cfg_limit), .trig(trig),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_offset(ev_offset),
    .ev_data(ev_data), .ev_last(ev_last), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_fail(wr_fail), .frame_irq(frame_irq), .mem_err(mem_err), .bw_err(bw_err));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [AW+DW-1:0] exp_q[$];
  logic [AW-1:0] m_base, m_incr, m_off;
  int m_circ, m_cnt, m_lim;
  logic [DW-1:0] seq = 16'hA000;
  int fail_idx = -1, mid_trig = 0;
  logic [AW-1:0] alt_base = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (wr_valid && wr_ready) begin
      if (exp_q.size() == 0) chk(0, "R1 unexpected write", {16'h0, wr_addr}, 32'h0);
      else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        chk({wr_addr, wr_data} == e, "R1 write addr/data", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic do_reset();
    rst_n = 0; trig = 0; ev_valid = 0; wr_ready = 0; wr_fail = 0; ev_last = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_off = 0; m_cnt = 0;
  endtask

  // events: n samples, stall: cycles of wr_ready low before first accept
  task automatic frame(input int n, input int stall);
    bit exp_mem, exp_bw;
    exp_mem = 0;
    @(negedge clk); trig = 1;
    m_base = cfg_base; m_incr = cfg_incr; m_circ = int'(cfg_circ); m_lim = int'(cfg_limit);
    @(negedge clk); trig = 0;
    #1;
    chk(mem_err == 0 && bw_err == 0, "R7 R8 flags cleared by trigger", {mem_err, bw_err}, 0);
    for (int i = 0; i < n; i++) begin
      ev_valid = 1; ev_offset = AW'(i * 4); ev_data = seq; ev_last = (i == n - 1);
      wr_fail = (i == fail_idx);
      if (i == fail_idx) exp_mem = 1;
      exp_q.push_back({m_base + m_off + AW'(i * 4), seq});
      seq++;
      if (mid_trig && i == 1) begin trig = 1; cfg_base = alt_base; end
      else trig = 0;
      wr_ready = (i == 0 && stall > 0) ? 1'b0 : 1'b1;
      if (i == 0) repeat (stall) begin @(negedge clk); trig = 0; end
      wr_ready = 1;
      @(negedge clk);
      trig = 0;
    end
    ev_valid = 0; ev_last = 0; wr_fail = 0;
    exp_bw = (m_lim != 0) && (n + stall > m_lim);
    #1;
    chk(frame_irq == 1, "R6 irq after last write", frame_irq, 1);
    chk(mem_err == exp_mem, "R7 mem_err", mem_err, exp_mem);
    chk(bw_err == exp_bw, "R8 bw_err", bw_err, exp_bw);
    @(negedge clk); #1;
    chk(frame_irq == 0, "R6 irq one cycle", frame_irq, 0);
    if (m_circ == 0) begin m_off = m_off + m_incr; m_cnt = 0; end
    else if (m_cnt + 1 >= m_circ) begin m_off = 0; m_cnt = 0; end
    else begin m_off = m_off + m_incr; m_cnt++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R10
    chk(!wr_valid && !ev_ready && !frame_irq && !mem_err && !bw_err, "R10 reset state",
        {wr_valid, ev_ready, frame_irq, mem_err, bw_err}, 0);
    // R9 idle: sample present but no frame
    ev_valid = 1; wr_ready = 1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(!wr_valid && !ev_ready, "R9 idle no request", {wr_valid, ev_ready}, 0);
    end
    ev_valid = 0;

    // R2 linear
    cfg_base = 16'h1000; cfg_incr = 16'h0020; cfg_circ = 0; cfg_limit = 0;
    frame(3, 0); frame(3, 0); frame(2, 0);

    // R3 ring of 3 frames
    do_reset();
    cfg_base = 16'h2000; cfg_incr = 16'h0010; cfg_circ = 3;
    for (int f = 0; f < 5; f++) frame(2, 0);

    // R4 zero step
    do_reset();
    cfg_base = 16'h3000; cfg_incr = 0; cfg_circ = 0;
    frame(2, 0); frame(2, 0);

    // R1 address wrap modulo 2^AW
    do_reset();
    cfg_base = 16'hFFF8; cfg_incr = 16'h0008; cfg_circ = 0;
    frame(3, 0); frame(3, 0);

    // R7 write failure, cleared at next trigger
    do_reset();
    cfg_base = 16'h4000; cfg_incr = 16'h0004;
    fail_idx = 1; frame(3, 0);
    fail_idx = -1; frame(3, 0);

    // R8 budget boundary: length 3 vs budget 3, then 4
    cfg_limit = 3;
    frame(3, 0);
    frame(3, 1);
    frame(2, 0);
    cfg_limit = 0;
    frame(3, 4);

    // R5 R9 mid-frame trigger and base change ignored
    do_reset();
    cfg_base = 16'h5000; cfg_incr = 16'h0100; cfg_limit = 0;
    fail_idx = 0; mid_trig = 1; alt_base = 16'h7000;
    frame(4, 0);
    fail_idx = -1; mid_trig = 0;
    frame(2, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all writes seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule